// File: doc/BRIEF.md
# Vectorised Instruction Expansion Sequencer

This block sits between instruction decode and an instruction queue. It takes one decoded three-operand scalar instruction (an opaque operation field plus destination and two source register numbers) and, based on a per-register table of "vectorised" marks and one global vector length, emits a series of plain scalar element instructions on its output handshake. An operand whose register is marked advances its register number by one for each element. An unmarked operand keeps the same register number throughout. This gives vector-style parallelism by re-issuing unmodified scalar operations over contiguous register ranges.

A predicate bitmask travels with each instruction. Bit i controls element i, and a cleared bit removes that element from the output stream. When no operand is marked, or the vector length is below two, the instruction leaves the block unchanged as a single operation. If a marked operand's range would run past the highest register number, the instruction is dropped and a one-cycle exception flag is raised; register numbers never wrap.

A configuration port writes the per-register marks and sets the vector length. A vector-length write aimed at destination register zero is discarded.

Top module: `vec_expand_seq`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `exc_o` is 0, `vl_o` is 0 and no register is marked.
- R2: An instruction none of whose three registers is marked leaves as exactly one output with the same operation field and register numbers.
- R3: With vector length L of at least 2 and at least one marked operand, element i (i = 0 to L-1) is emitted in ascending i order. It carries the same operation field, each marked register number plus i, and each unmarked register number unchanged.
- R4: Bit i of `in_pred` (bit 0 = element 0) gates element i of a vectorised instruction. A cleared bit produces no output entry, and later elements still follow in order.
- R5: `in_ready` stays 0 until every element of the accepted instruction has been taken at the output. While `out_valid` is 1 and `out_ready` is 0, the output fields stay stable.
- R6: A configuration write with `cfg_kind` = 1 and nonzero `cfg_reg` sets the vector length to `cfg_len`, capped at 32, and `vl_o` shows it from the next cycle. The same write with `cfg_reg` = 0 leaves the length unchanged.
- R7: If a marked operand's base register plus L-1 exceeds 31, no element is emitted and `exc_o` is 1 for exactly one cycle, the cycle after acceptance.
- R8: With vector length 0 or 1, an instruction with marked operands is emitted once, unchanged, whatever its predicate.
- R9: A configuration write with `cfg_kind` = 0 sets the mark of register `cfg_reg` to `cfg_flag`. Clearing a mark returns that register to scalar behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: write register mark, 1: set vector length |
| cfg_reg | input | 5 | Register whose mark is written, or destination of a length set |
| cfg_flag | input | 1 | Mark value for a kind-0 write |
| cfg_len | input | 8 | Requested vector length for a kind-1 write |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_opc | input | 7 | Opaque operation field |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_pred | input | 32 | Per-element predicate bits |
| out_valid | output | 1 | Element instruction offered |
| out_ready | input | 1 | Queue takes the element |
| out_opc | output | 7 | Element operation field |
| out_rd | output | 5 | Element destination register |
| out_rs1 | output | 5 | Element first source register |
| out_rs2 | output | 5 | Element second source register |
| exc_o | output | 1 | One-cycle register-range exception |
| vl_o | output | 6 | Current vector length |

## Verification
The assertions check the handshake properties on every cycle. These are: output fields held under back-pressure, no new instruction accepted while an element is pending, the exception flag lasting a single cycle after an acceptance and never coinciding with an output, and the length never exceeding its cap. The register stepping order, predicate gating, scalar pass-through and discarded length writes depend on the contents of the whole element stream. Only the bench's reference model can show those, across its directed and pseudo-random scenarios.

// File: rtl/vec_expand_seq.sv
module vec_expand_seq #(
  parameter int NREG = 32,
  parameter int OPW = 7,
  parameter int VMAX = 32,
  parameter int LENW = 8,
  localparam int RW = $clog2(NREG),
  localparam int PW = $clog2(VMAX),
  localparam int LW = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_kind,
  input  logic [RW-1:0]   cfg_reg,
  input  logic            cfg_flag,
  input  logic [LENW-1:0] cfg_len,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_opc,
  input  logic [RW-1:0]   in_rd,
  input  logic [RW-1:0]   in_rs1,
  input  logic [RW-1:0]   in_rs2,
  input  logic [VMAX-1:0] in_pred,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OPW-1:0]  out_opc,
  output logic [RW-1:0]   out_rd,
  output logic [RW-1:0]   out_rs1,
  output logic [RW-1:0]   out_rs2,
  output logic            exc_o,
  output logic [LW-1:0]   vl_o
);

  logic [NREG-1:0] vflag;
  logic [LW-1:0]   vl_q;
  logic            busy, exc_q;
  logic [LW-1:0]   idx, cnt;
  logic [OPW-1:0]  opc_q;
  logic [RW-1:0]   rd_q, rs1_q, rs2_q;
  logic            mrd_q, mrs1_q, mrs2_q;
  logic [VMAX-1:0] pred_q;

  logic acc, f_rd, f_rs1, f_rs2, vec_mode, ovf, live, step, last;

  assign in_ready = ~busy;
  assign acc      = in_valid & ~busy;
  assign f_rd     = vflag[in_rd];
  assign f_rs1    = vflag[in_rs1];
  assign f_rs2    = vflag[in_rs2];
  assign vec_mode = (f_rd | f_rs1 | f_rs2) && (vl_q > LW'(1));

  always_comb begin
    ovf = 1'b0;
    if (f_rd  && (int'(in_rd)  + int'(vl_q) > NREG)) ovf = 1'b1;
    if (f_rs1 && (int'(in_rs1) + int'(vl_q) > NREG)) ovf = 1'b1;
    if (f_rs2 && (int'(in_rs2) + int'(vl_q) > NREG)) ovf = 1'b1;
  end

  assign live = pred_q[idx[PW-1:0]];
  assign step = busy & (~live | out_ready);
  assign last = (idx == cnt - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vflag <= '0;
      vl_q  <= '0;
    end else if (cfg_we) begin
      if (!cfg_kind)
        vflag[cfg_reg] <= cfg_flag;
      else if (cfg_reg != '0)
        vl_q <= (cfg_len > LENW'(VMAX)) ? LW'(VMAX) : LW'(cfg_len);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      exc_q  <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      opc_q  <= '0;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      mrd_q  <= 1'b0;
      mrs1_q <= 1'b0;
      mrs2_q <= 1'b0;
      pred_q <= '0;
    end else begin
      exc_q <= acc & vec_mode & ovf;
      if (acc && !(vec_mode && ovf)) begin
        busy   <= 1'b1;
        idx    <= '0;
        cnt    <= vec_mode ? vl_q : LW'(1);
        opc_q  <= in_opc;
        rd_q   <= in_rd;
        rs1_q  <= in_rs1;
        rs2_q  <= in_rs2;
        mrd_q  <= vec_mode & f_rd;
        mrs1_q <= vec_mode & f_rs1;
        mrs2_q <= vec_mode & f_rs2;
        pred_q <= vec_mode ? in_pred : '1;
      end else if (step) begin
        if (last) busy <= 1'b0;
        else      idx  <= idx + LW'(1);
      end
    end
  end

  assign out_valid = busy & live;
  assign out_opc   = opc_q;
  assign out_rd    = rd_q  + (mrd_q  ? RW'(idx) : '0);
  assign out_rs1   = rs1_q + (mrs1_q ? RW'(idx) : '0);
  assign out_rs2   = rs2_q + (mrs2_q ? RW'(idx) : '0);
  assign exc_o     = exc_q;
  assign vl_o      = vl_q;

endmodule

// File: rtl/vec_expand_seq_chk.sv
module vec_expand_seq_chk #(
  parameter int OPW = 7,
  parameter int RW = 5,
  parameter int VMAX = 32,
  parameter int LW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [OPW-1:0] out_opc,
  input logic [RW-1:0]  out_rd,
  input logic [RW-1:0]  out_rs1,
  input logic [RW-1:0]  out_rs2,
  input logic           exc_o,
  input logic [LW-1:0]  vl_o
);

  a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opc) && $stable(out_rd)
                                && $stable(out_rs1) && $stable(out_rs2));

  a_r5_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r7_exc_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> $past(in_valid && in_ready));

  a_r7_exc_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !out_valid);

  a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= LW'(VMAX));

endmodule

bind vec_expand_seq vec_expand_seq_chk #(.OPW(OPW), .RW(RW), .VMAX(VMAX), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
  .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
  .exc_o(exc_o), .vl_o(vl_o)
);

// File: tb/vec_expand_seq_bench.sv
module vec_expand_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_kind = 0, cfg_flag = 0;
  logic [4:0]  cfg_reg = 0;
  logic [7:0]  cfg_len = 0;
  logic        in_valid = 0, in_ready;
  logic [6:0]  in_opc = 0;
  logic [4:0]  in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic [31:0] in_pred = 0;
  logic        out_valid, out_ready = 1'b1;
  logic [6:0]  out_opc;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic        exc_o;
  logic [5:0]  vl_o;

  vec_expand_seq u_vec_expand_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_reg(cfg_reg), .cfg_flag(cfg_flag), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_opc(in_opc),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_pred(in_pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .exc_o(exc_o), .vl_o(vl_o)
  );

  int checks = 0, fails = 0;
  int got_exc = 0, exp_exc = 0, fired = 0, cyc = 0, stall_mode = 0;
  bit mflag [32];
  int mvl = 0;
  logic [21:0] expq [$];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    logic nr;
    cyc++;
    nr = (stall_mode == 0) || (cyc % 3 == 0);
    if (rst_n) begin
      if (out_valid) begin
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3: got element %h expected none", {out_opc, out_rd, out_rs1, out_rs2});
        end else begin
          checks++;
          if ({out_opc, out_rd, out_rs1, out_rs2} != expq[0]) begin
            fails++;
            $display("FAIL R3: got %h expected %h", {out_opc, out_rd, out_rs1, out_rs2}, expq[0]);
          end
          if (nr) begin
            void'(expq.pop_front());
            fired++;
          end
        end
      end
      if (in_ready && expq.size() != 0) begin
        checks++; fails++;
        $display("FAIL R5: got in_ready 1 expected 0 with %0d pending", expq.size());
      end
      if (exc_o) got_exc++;
    end
    out_ready <= nr;
  end

  task automatic set_mark(int r, bit v);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 0; cfg_reg = 5'(r); cfg_flag = v;
    @(negedge clk);
    cfg_we = 0;
    mflag[r] = v;
  endtask

  task automatic set_len(int d, int len);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 1; cfg_reg = 5'(d); cfg_len = 8'(len);
    @(negedge clk);
    cfg_we = 0;
    if (d != 0) mvl = (len > 32) ? 32 : len;
  endtask

  task automatic model(int op, int rd, int r1, int r2, logic [31:0] p);
    bit vec;
    vec = (mflag[rd] || mflag[r1] || mflag[r2]) && mvl >= 2;
    if (!vec) begin
      expq.push_back({7'(op), 5'(rd), 5'(r1), 5'(r2)});
    end else if ((mflag[rd] && rd + mvl > 32) || (mflag[r1] && r1 + mvl > 32) ||
                 (mflag[r2] && r2 + mvl > 32)) begin
      exp_exc++;
    end else begin
      for (int i = 0; i < mvl; i++)
        if (p[i])
          expq.push_back({7'(op), 5'(rd + (mflag[rd] ? i : 0)),
                          5'(r1 + (mflag[r1] ? i : 0)), 5'(r2 + (mflag[r2] ? i : 0))});
    end
  endtask

  task automatic send(int op, int rd, int r1, int r2, logic [31:0] p);
    @(negedge clk);
    in_valid = 1; in_opc = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(r1); in_rs2 = 5'(r2); in_pred = p;
    while (!in_ready) @(negedge clk);
    #1 model(op, rd, r1, r2, p);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(in_ready && expq.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5: got hang expected completion (watchdog)");
    report();
    $finish;
  end

  initial begin
    int f0, seed;
    repeat (3) @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 vl", int'(vl_o), 0);
    chk("R1 exc", int'(exc_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 plain scalar
    send(7'h33, 3, 4, 5, 32'h0);
    drain();

    // R6 length writes
    set_len(5, 3);
    @(negedge clk); chk("R6 set", int'(vl_o), 3);
    set_len(0, 7);
    @(negedge clk); chk("R6 x0 ignored", int'(vl_o), 3);
    set_len(3, 40);
    @(negedge clk); chk("R6 cap", int'(vl_o), 32);
    set_len(3, 3);

    // R3 mixed vector/scalar operands
    set_mark(7, 1); set_mark(1, 1);
    f0 = fired;
    send(7'h33, 7, 4, 1, 32'hFFFF_FFFF);
    drain();
    chk("R3 count", fired - f0, 3);

    // R4 predicate gating
    f0 = fired;
    send(7'h13, 7, 4, 1, 32'h5);
    drain();
    chk("R4 count", fired - f0, 2);

    // R5 back-pressure with longer vector
    stall_mode = 1;
    set_len(2, 8);
    set_mark(10, 1);
    f0 = fired;
    send(7'h3B, 10, 10, 2, 32'hFFFF_FFFF);
    send(7'h3B, 12, 10, 1, 32'h0000_00A5);
    drain();
    chk("R5 count", fired - f0, 12);
    stall_mode = 0;

    // R7 range overflow
    set_mark(30, 1);
    set_len(2, 3);
    f0 = fired;
    send(7'h33, 30, 4, 5, 32'hFFFF_FFFF);
    drain();
    chk("R7 exc", got_exc, exp_exc);
    chk("R7 no element", fired - f0, 0);

    // R8 length 1 and 0 act as scalar
    set_len(2, 1);
    f0 = fired;
    send(7'h33, 30, 7, 1, 32'h0);
    drain();
    set_len(2, 0);
    send(7'h23, 7, 1, 10, 32'h0);
    drain();
    chk("R8 count", fired - f0, 2);

    // R9 unmark returns scalar behaviour
    set_len(2, 4);
    set_mark(7, 0); set_mark(1, 0);
    f0 = fired;
    send(7'h33, 7, 1, 1, 32'hF);
    drain();
    chk("R9 count", fired - f0, 1);

    // mixed pseudo-random stream
    seed = 12345;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      if (n % 5 == 0) set_mark((seed >>> 8) & 31, ((seed >>> 20) & 1) != 0);
      if (n % 7 == 0) set_len(1 + ((seed >>> 4) & 3), (seed >>> 12) & 7);
      stall_mode = (seed >>> 16) & 1;
      send((seed >>> 3) & 127, (seed >>> 9) & 31, (seed >>> 14) & 31, (seed >>> 19) & 31,
           32'(seed ^ (seed << 7)));
    end
    drain();
    stall_mode = 0;
    chk("R7 exc random", got_exc, exp_exc);
    chk("R3 queue empty", expq.size(), 0);

    report();
    $finish;
  end
endmodule